// File: doc/BRIEF.md
# Port-Filtered Fabric Traffic Counter

This block counts interconnect traffic events: reads and writes on two host links, on a coherent link and on the memory-mapped I/O path. Each event source delivers a one-cycle pulse together with a 2-bit tag that names the port the traffic belongs to. Software picks one event code through a control register. The block counts that event in one of two modes. In overall mode every port is counted. In port mode only traffic whose tag matches a programmed port number is counted. The result is read as a 64-bit register: a 60-bit count, with the selected event code echoed in the top nibble.

A second 64-bit register holds a free-running count of clock cycles. Software cannot clear or stop it, so it serves as a time base for rate calculations. Both 64-bit registers are read as two 32-bit words. Reading the low word captures the high word into a shadow register, so that the following high-word read belongs to the same snapshot.

Register access uses a one-beat request port. The port has no back-pressure: a request presented with `acc_valid` is always taken on that clock edge. A read answers on the next cycle with `rsp_valid` and `rsp_data`. A write gives no response. There is no ready signal, so the requester never waits.

Top module: `fab_traffic_counter`

## Requirements
- R1: After reset every register reads zero. The control word at byte address 0x20 has these fields: bit 0 is the clear control, bit 8 is the hold control, bits 19:16 are the event select, bits 21:20 are the port number and bit 23 is the port-filter enable. Every other bit reads zero, and the word at 0x24 reads zero.
- R2: Event codes map as follows: 0 is link-0 read, 1 is link-0 write, 2 is link-1 read, 3 is link-1 write, 4 is coherent read, 5 is coherent write, 6 is MMIO read and 7 is MMIO write. Only pulses on `ev_pulse[sel]` are counted, and the count rises by at most one per clock even when several sources pulse together.
- R3: With bit 23 clear, a pulse is counted whatever its port tag. With bit 23 set, a pulse is counted only when its tag `ev_port[2*i+1:2*i]` equals bits 21:20.
- R4: A control write that changes the event select, the port number or the filter enable clears the count on that edge. A control write that leaves these three fields unchanged does not clear the count.
- R5: While bit 8 is set, the count holds its value and incoming pulses are lost. Counting resumes once the bit is cleared.
- R6: While bit 0 is set, the count is held at zero. This takes priority over the hold control.
- R7: The counter register has its low word at 0x28 and its high word at 0x2C. Bits 59:0 are the count and bits 63:60 echo the event select. The echo matches a newly written select from the second clock edge after the write onward.
- R8: Reading a low word (0x28 or 0x30) copies the upper 32 bits of that register, as they stand at that moment, into a shadow. Reading the matching high word (0x2C or 0x34) returns the shadow and not the live value.
- R9: The clock register, with its low word at 0x30 and its high word at 0x34, advances by one on every clock after reset. The clear and hold controls have no effect on it.
- R10: A read request is answered exactly one cycle later, with `rsp_valid` high for one cycle. No other cycle raises `rsp_valid`. Writes to any address other than 0x20 are ignored. Reads of unmapped addresses return zero.
- R11: Event selects 8 to 15 count nothing, but the select is still echoed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register request present (always accepted) |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte address of the 32-bit word |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_data | output | 32 | Read data |
| ev_pulse | input | 8 | One-cycle event pulse per event code |
| ev_port | input | 16 | Port tag of event i in bits 2*i+1:2*i |

## Verification
The bound checker watches the following on every cycle: the count never moves by more than one step except back to zero, the clear and hold controls act on the count, configuration changes clear it, the clock register steps by exactly one, the echo settles two edges after a control write, and the read response timing holds. Only the bench scenarios can show the values themselves. These are the selection of one code among eight, port matching under the filter, the difference between same-value and changing control writes, the shadow keeping a stale high word, and that ignored writes leave the control word and the count untouched.

// File: rtl/fabcnt_pkg.sv
package fabcnt_pkg;
  localparam int REG_W  = 32;
  localparam int SEL_W  = 4;
  localparam int PID_W  = 2;
  localparam int WIDE_W = 64;

  localparam logic [7:0] A_CTRL_LO = 8'h20;
  localparam logic [7:0] A_CTRL_HI = 8'h24;
  localparam logic [7:0] A_WIDE0   = 8'h28;  // first 64-bit register, next one 8 bytes above

  localparam int B_CLR  = 0;
  localparam int B_HOLD = 8;
  localparam int B_SEL  = 16;
  localparam int B_PID  = 20;
  localparam int B_FILT = 23;

  typedef struct packed {
    logic             filt;
    logic [PID_W-1:0] pid;
    logic [SEL_W-1:0] sel;
    logic             hold;
    logic             clr;
  } fab_ctrl_t;
endpackage

// File: rtl/fab_ctrl_reg.sv
module fab_ctrl_reg
  import fabcnt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output fab_ctrl_t        ctrl,
  output logic             cfg_chg
);
  fab_ctrl_t nxt;

  always_comb begin
    nxt.clr  = wdata[B_CLR];
    nxt.hold = wdata[B_HOLD];
    nxt.sel  = wdata[B_SEL +: SEL_W];
    nxt.pid  = wdata[B_PID +: PID_W];
    nxt.filt = wdata[B_FILT];
  end

  // a change of what is being counted restarts the count
  assign cfg_chg = wr_en && ((nxt.sel != ctrl.sel) || (nxt.pid != ctrl.pid) ||
                             (nxt.filt != ctrl.filt));

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl <= '0;
    else if (wr_en) ctrl <= nxt;
  end
endmodule

// File: rtl/fab_evt_filter.sv
module fab_evt_filter
  import fabcnt_pkg::*;
#(
  parameter int NUM_EVT = 8
) (
  input  logic [NUM_EVT-1:0]       ev_pulse,
  input  logic [NUM_EVT*PID_W-1:0] ev_port,
  input  fab_ctrl_t                ctrl,
  output logic                     hit
);
  logic [NUM_EVT-1:0] match;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_src
    assign match[i] = ev_pulse[i] &&
                      (!ctrl.filt || (ev_port[i*PID_W +: PID_W] == ctrl.pid));
  end

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (ctrl.sel == SEL_W'(i)) hit = match[i];
    end
  end
endmodule

// File: rtl/fab_evt_counter.sv
module fab_evt_counter
  import fabcnt_pkg::*;
#(
  parameter int CNT_W = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             cfg_chg,
  input  fab_ctrl_t        ctrl,
  output logic [CNT_W-1:0] cnt,
  output logic [SEL_W-1:0] echo
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      echo <= '0;
    end else begin
      echo <= ctrl.sel;
      if (cfg_chg || ctrl.clr) cnt <= '0;
      else if (!ctrl.hold && hit) cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/fab_free_clk.sv
module fab_free_clk #(
  parameter int CLK_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CLK_W-1:0] cyc
);
  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= '0;
    else cyc <= cyc + CLK_W'(1);
  end
endmodule

// File: rtl/fab_rd_port.sv
module fab_rd_port
  import fabcnt_pkg::*;
#(
  parameter int NWIDE  = 2,
  parameter int ADDR_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [REG_W-1:0]             ctrl_word,
  input  logic [NWIDE-1:0][WIDE_W-1:0] wide,
  output logic                         rsp_valid,
  output logic [REG_W-1:0]             rsp_data
);
  logic [NWIDE-1:0][REG_W-1:0] shadow;
  logic [REG_W-1:0]            rd_mux;

  for (genvar k = 0; k < NWIDE; k++) begin : g_shadow
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(A_WIDE0) + ADDR_W'(8 * k);
    always_ff @(posedge clk) begin
      if (!rst_n) shadow[k] <= '0;
      else if (rd_en && addr == LO) shadow[k] <= wide[k][WIDE_W-1:REG_W];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(A_CTRL_LO)) rd_mux = ctrl_word;
    for (int k = 0; k < NWIDE; k++) begin
      if (addr == ADDR_W'(A_WIDE0) + ADDR_W'(8 * k))     rd_mux = wide[k][REG_W-1:0];
      if (addr == ADDR_W'(A_WIDE0) + ADDR_W'(8 * k + 4)) rd_mux = shadow[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_data <= rd_mux;
    end
  end
endmodule

// File: rtl/fab_traffic_counter.sv
module fab_traffic_counter
  import fabcnt_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int CNT_W   = 60,
  parameter int CLK_W   = 64,
  parameter int ADDR_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_valid,
  input  logic                       acc_write,
  input  logic [ADDR_W-1:0]          acc_addr,
  input  logic [REG_W-1:0]           acc_wdata,
  output logic                       rsp_valid,
  output logic [REG_W-1:0]           rsp_data,
  input  logic [NUM_EVT-1:0]         ev_pulse,
  input  logic [NUM_EVT*PID_W-1:0]   ev_port
);
  localparam int CNT_FIELD = WIDE_W - SEL_W;

  fab_ctrl_t              ctrl;
  logic                   cfg_chg;
  logic                   hit;
  logic [CNT_W-1:0]       cnt_q;
  logic [SEL_W-1:0]       echo_q;
  logic [CLK_W-1:0]       cyc_q;
  logic [REG_W-1:0]       ctrl_word;
  logic [1:0][WIDE_W-1:0] wide;
  logic                   ctrl_wr;

  assign ctrl_wr = acc_valid && acc_write && (acc_addr == ADDR_W'(A_CTRL_LO));

  fab_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wdata(acc_wdata),
    .ctrl(ctrl), .cfg_chg(cfg_chg)
  );

  fab_evt_filter #(.NUM_EVT(NUM_EVT)) u_filt (
    .ev_pulse(ev_pulse), .ev_port(ev_port), .ctrl(ctrl), .hit(hit)
  );

  fab_evt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hit(hit), .cfg_chg(cfg_chg), .ctrl(ctrl),
    .cnt(cnt_q), .echo(echo_q)
  );

  fab_free_clk #(.CLK_W(CLK_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .cyc(cyc_q)
  );

  always_comb begin
    ctrl_word                   = '0;
    ctrl_word[B_CLR]            = ctrl.clr;
    ctrl_word[B_HOLD]           = ctrl.hold;
    ctrl_word[B_SEL +: SEL_W]   = ctrl.sel;
    ctrl_word[B_PID +: PID_W]   = ctrl.pid;
    ctrl_word[B_FILT]           = ctrl.filt;
  end

  assign wide[0] = {echo_q, CNT_FIELD'(cnt_q)};
  assign wide[1] = WIDE_W'(cyc_q);

  fab_rd_port #(.NWIDE(2), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(acc_valid && !acc_write), .addr(acc_addr),
    .ctrl_word(ctrl_word), .wide(wide), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );
endmodule

// File: rtl/fabcnt_chk.sv
module fabcnt_chk
  import fabcnt_pkg::*;
#(
  parameter int CNT_W  = 60,
  parameter int CLK_W  = 64,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [REG_W-1:0]  acc_wdata,
  input logic              rsp_valid,
  input logic [CNT_W-1:0]  cnt,
  input logic [SEL_W-1:0]  echo,
  input logic [CLK_W-1:0]  cyc,
  input logic              ctrl_clr,
  input logic              ctrl_hold,
  input logic              cfg_chg
);
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_W'(1)) || (cnt == '0));

  a_r4_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> cnt == '0);

  a_r5_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_hold && !ctrl_clr && !cfg_chg) |=> $stable(cnt));

  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_clr |=> cnt == '0);

  a_r7_echo_settles: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_addr == ADDR_W'(A_CTRL_LO)) |=> ##1
      echo == $past(acc_wdata[B_SEL +: SEL_W], 2));

  a_r9_clock_steps: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cyc == $past(cyc) + CLK_W'(1));

  a_r10_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rsp_valid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_write) |=> !rsp_valid);
endmodule

bind fab_traffic_counter fabcnt_chk #(.CNT_W(CNT_W), .CLK_W(CLK_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rsp_valid(rsp_valid),
  .cnt(cnt_q), .echo(echo_q), .cyc(cyc_q), .ctrl_clr(ctrl.clr),
  .ctrl_hold(ctrl.hold), .cfg_chg(cfg_chg)
);

// File: tb/test_fab_traffic_counter.sv
module test_fab_traffic_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [7:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [7:0]  ev_pulse = '0;
  logic [15:0] ev_port = '0;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  fab_traffic_counter i_fab_traffic_counter (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .ev_pulse(ev_pulse), .ev_port(ev_port)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(input bit clr, input bit hold, input int sel,
                                     input int pid, input bit filt);
    logic [31:0] w = '0;
    w[0] = clr; w[8] = hold; w[19:16] = 4'(sel); w[21:20] = 2'(pid); w[23] = filt;
    return w;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
    @(negedge clk);
    chk("R10 rsp_valid", 64'(rsp_valid), 64'd1);
    d = rsp_data;
    acc_valid = 1'b0;
  endtask

  task automatic rd_cnt(output logic [59:0] c, output logic [3:0] e);
    logic [31:0] lo, hi;
    rd(8'h28, lo);
    rd(8'h2C, hi);
    c = {hi[27:0], lo};
    e = hi[31:28];
  endtask

  task automatic pulse(input int code, input int port, input int times);
    for (int i = 0; i < times; i++) begin
      @(negedge clk);
      ev_pulse = '0; ev_pulse[code] = 1'b1; ev_port[2*code +: 2] = 2'(port);
      @(negedge clk);
      ev_pulse = '0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d; logic [59:0] c; logic [3:0] e;
    rd(8'h20, d); chk("R1 ctrl after reset", 64'(d), 0);
    rd(8'h24, d); chk("R1 ctrl high word", 64'(d), 0);
    rd_cnt(c, e); chk("R1 count after reset", 64'(c), 0); chk("R1 echo after reset", 64'(e), 0);
  endtask

  task automatic t_overall;
    logic [59:0] c; logic [3:0] e;
    wr(8'h20, cw(0, 0, 2, 0, 0));
    pulse(2, 0, 1); pulse(2, 3, 1); pulse(2, 1, 1);
    pulse(3, 0, 2); pulse(0, 0, 1);
    rd_cnt(c, e);
    chk("R2 overall mode counts code 2 only", 64'(c), 3);
    chk("R7 echo code 2", 64'(e), 2);
    @(negedge clk); ev_pulse = 8'hFF; ev_port = '0;
    @(negedge clk); ev_pulse = '0;
    rd_cnt(c, e);
    chk("R2 one increment for simultaneous pulses", 64'(c), 4);
  endtask

  task automatic t_filter;
    logic [59:0] c; logic [3:0] e; logic [31:0] d;
    wr(8'h20, cw(0, 0, 7, 2, 1));
    rd(8'h20, d); chk("R1 ctrl readback", 64'(d), 64'(cw(0, 0, 7, 2, 1)));
    pulse(7, 2, 2); pulse(7, 1, 3); pulse(7, 0, 1);
    rd_cnt(c, e);
    chk("R3 port filter counts matching tag", 64'(c), 2);
    chk("R7 echo code 7", 64'(e), 7);
  endtask

  task automatic t_change;
    logic [59:0] c; logic [3:0] e;
    wr(8'h20, cw(0, 0, 7, 2, 1));
    rd_cnt(c, e); chk("R4 same-value write keeps count", 64'(c), 2);
    wr(8'h20, cw(0, 0, 7, 1, 1));
    rd_cnt(c, e); chk("R4 port change clears", 64'(c), 0);
    pulse(7, 1, 4);
    wr(8'h20, cw(0, 0, 7, 1, 0));
    rd_cnt(c, e); chk("R4 filter change clears", 64'(c), 0);
    pulse(7, 3, 1);
    wr(8'h20, cw(0, 0, 6, 1, 0));
    rd_cnt(c, e); chk("R4 select change clears", 64'(c), 0);
  endtask

  task automatic t_hold;
    logic [59:0] c; logic [3:0] e;
    wr(8'h20, cw(0, 0, 5, 0, 0));
    pulse(5, 1, 3);
    wr(8'h20, cw(0, 1, 5, 0, 0));
    pulse(5, 1, 4);
    rd_cnt(c, e); chk("R5 hold keeps count", 64'(c), 3);
    wr(8'h20, cw(0, 0, 5, 0, 0));
    pulse(5, 2, 2);
    rd_cnt(c, e); chk("R5 counting resumes", 64'(c), 5);
  endtask

  task automatic t_clear;
    logic [59:0] c; logic [3:0] e;
    wr(8'h20, cw(1, 1, 5, 0, 0));
    pulse(5, 0, 3);
    rd_cnt(c, e); chk("R6 clear beats hold, stays zero", 64'(c), 0);
    wr(8'h20, cw(0, 0, 5, 0, 0));
    pulse(5, 0, 2);
    rd_cnt(c, e); chk("R6 counts after clear released", 64'(c), 2);
  endtask

  task automatic t_clock;
    logic [31:0] a, b;
    rd(8'h30, a);
    repeat (10) @(negedge clk);
    rd(8'h30, b);
    chk("R9 clock steps per cycle", 64'(b - a), 12);
    wr(8'h20, cw(1, 1, 5, 0, 0));
    rd(8'h30, a);
    repeat (5) @(negedge clk);
    rd(8'h30, b);
    chk("R9 clock ignores clear and hold", 64'(b - a), 7);
    rd(8'h34, b); chk("R8 clock high via shadow", 64'(b), 0);
    wr(8'h20, cw(0, 0, 5, 0, 0));
  endtask

  task automatic t_shadow;
    logic [31:0] d;
    wr(8'h20, cw(0, 0, 3, 0, 0));
    repeat (2) @(negedge clk);
    rd(8'h28, d);
    wr(8'h20, cw(0, 0, 4, 0, 0));
    repeat (3) @(negedge clk);
    rd(8'h2C, d); chk("R8 high word is latched shadow", 64'(d[31:28]), 3);
    rd(8'h28, d);
    rd(8'h2C, d); chk("R8 new low read refreshes shadow", 64'(d[31:28]), 4);
  endtask

  task automatic t_ignored;
    logic [31:0] d; logic [59:0] c; logic [3:0] e;
    pulse(4, 0, 2);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h30, 32'h0000_0000);
    rd(8'h20, d); chk("R10 ignored writes leave ctrl", 64'(d), 64'(cw(0, 0, 4, 0, 0)));
    rd_cnt(c, e); chk("R10 ignored writes leave count", 64'(c), 2);
    rd(8'h3C, d); chk("R10 unmapped read is zero", 64'(d), 0);
  endtask

  task automatic t_outofrange;
    logic [59:0] c; logic [3:0] e;
    wr(8'h20, cw(0, 0, 9, 0, 0));
    @(negedge clk); ev_pulse = 8'hFF;
    repeat (3) @(negedge clk);
    ev_pulse = '0;
    rd_cnt(c, e);
    chk("R11 code 9 counts nothing", 64'(c), 0);
    chk("R11 code 9 still echoed", 64'(e), 9);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_overall();
    t_filter();
    t_change();
    t_hold();
    t_clear();
    t_clock();
    t_shadow();
    t_ignored();
    t_outofrange();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule